// File: doc/BRIEF.md
# Cyclic-Prefix Symbol Timing Detector

This block locates OFDM symbol boundaries in a stream of complex baseband samples. A cyclic prefix is a copy of the end of the symbol body, so each sample is multiplied by the conjugate of the sample one FFT length later. These products are summed over a window that is one prefix long and slides across the stream. The squared magnitude of that sum peaks when the window sits exactly on a prefix.

Once per symbol period, the block reports four values. The first is the position of the first prefix sample. The second is a strobe that starts the FFT window. The third is the phase of the correlation sum at the peak, which is the residual fractional frequency offset. The fourth is the signed change in symbol position since the previous report. That change is the drift a sample-clock tracking loop averages to estimate the sampling rate error. The angle comes from a short sequential rotation search, which is accurate enough for a coarse estimate.

Top module: `cp_sym_timing`

## Requirements
- R1: While reset is high, sym_strobe and drift_valid are 0, and sym_start, freq_phase and drift are 0.
- R2: One report is made for each period of NSYM = NFFT + NCP valid samples, counted from reset. Period 0 (samples 0 to NSYM-1) produces no report. The first report covers samples NSYM to 2·NSYM-1. sym_strobe is high for exactly one cycle per report, and all outputs hold their values between strobes.
- R3: For the valid sample with index m, the metric sum is S(m) = Σ x[n]·conj(x[n+NFFT]) over n = m-NFFT-NCP+1 … m-NFFT. A product whose partner sample does not yet exist counts as zero.
- R4: sym_start is (m+1) mod NSYM for the m in the period where |S(m)|² is largest. This is the index, within the period, of the first cyclic-prefix sample.
- R5: When several m in a period share the largest metric, the earliest one is reported.
- R6: freq_phase is the angle of S at the reported peak, in two's complement units where 2^PHASE_W units make a full turn. The value 0 is the positive real axis, and counter-clockwise is positive. For PHASE_W = 16, the error is at most 16 units.
- R7: drift is sym_start minus the previous sym_start, wrapped into the range (-NSYM/2, NSYM/2] as a signed value.
- R8: On the first report after reset, drift_valid is 0 and drift is 0. On every later report, drift_valid is 1.
- R9: Full-scale inputs do not overflow any product or sum. A constant input of -32768 on both I and Q gives phase 0 at every report.
- R10: Samples count only while in_valid is high. Idle cycles between samples do not change any reported value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| sym_strobe | output | 1 | One-cycle report strobe, starts the FFT window |
| sym_start | output | IDX_W | Index of the first prefix sample within the period |
| freq_phase | output | PHASE_W | Angle of the correlation at the peak |
| drift | output | IDX_W+1 | Signed change in symbol start since the last report |
| drift_valid | output | 1 | drift carries a real measurement |

## Verification
The bound checker checks the following properties on every cycle:
- the strobe is a single-cycle pulse;
- reports are at least one symbol period apart;
- the outputs hold their values between reports;
- sym_start stays below NSYM;
- drift lies in its wrapped range;
- drift_valid is low on the first report and high on every later one.

Some behaviour can only be shown by the bench's scenarios, which compare each report with a correlation model built from R3. These cover where the peak lands, the tie rule, the phase value under an applied frequency rotation, drift across a timing slip that wraps the period boundary, full-scale arithmetic, and results that do not change when idle gaps are inserted between samples.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  // Arctangent of 2^-k, in units where 65536 is one full turn.
  function automatic logic [15:0] atan_turn16(input logic [3:0] k);
    logic [15:0] v;
    case (k)
      4'd0:  v = 16'd8192;
      4'd1:  v = 16'd4836;
      4'd2:  v = 16'd2555;
      4'd3:  v = 16'd1297;
      4'd4:  v = 16'd651;
      4'd5:  v = 16'd326;
      4'd6:  v = 16'd163;
      4'd7:  v = 16'd81;
      4'd8:  v = 16'd41;
      4'd9:  v = 16'd20;
      4'd10: v = 16'd10;
      4'd11: v = 16'd5;
      4'd12: v = 16'd3;
      4'd13: v = 16'd1;
      default: v = 16'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cpt_ram.sv
module cpt_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Read-first single port, which maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cpt_corr.sv
module cpt_corr #(
  parameter int DW   = 16,
  parameter int NFFT = 2048,
  parameter int NCP  = 512,
  localparam int NSYM = NFFT + NCP,
  localparam int IW   = $clog2(NSYM),
  localparam int PRW  = 2*DW + 1,
  localparam int SW   = PRW + $clog2(NCP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 s_valid,
  output logic                 s_full,
  output logic [IW-1:0]        s_pos,
  output logic signed [SW-1:0] s_re,
  output logic signed [SW-1:0] s_im
);
  localparam int FA = $clog2(NFFT);
  localparam int CA = $clog2(NCP);

  function automatic logic signed [PRW-1:0] xp(input logic signed [DW-1:0] v);
    return {{(PRW-DW){v[DW-1]}}, v};
  endfunction
  function automatic logic signed [SW-1:0] xs(input logic signed [PRW-1:0] v);
    return {{(SW-PRW){v[PRW-1]}}, v};
  endfunction

  logic [FA-1:0] wptr;
  logic [CA-1:0] pptr;
  logic [IW-1:0] pos;
  logic [IW:0]   seen;
  logic          cwrap;

  // Stage 1 registers
  logic                 v1, pair1, full1;
  logic [IW-1:0]        pos1;
  logic signed [DW-1:0] n_i, n_q;
  // Stage 2 registers
  logic                  v2, full2;
  logic [IW-1:0]         pos2;
  logic signed [PRW-1:0] p2_re, p2_im;
  // Stage 3 registers
  logic                  v3, full3, ok3;
  logic [IW-1:0]         pos3;
  logic signed [PRW-1:0] p3_re, p3_im;

  logic [2*DW-1:0]  old_smp;
  logic [2*PRW-1:0] old_prod;

  cpt_ram #(.W(2*DW), .DEPTH(NFFT)) u_smp (
    .clk(clk), .we(in_valid), .addr(wptr),
    .wdata({in_i, in_q}), .rdata(old_smp));

  cpt_ram #(.W(2*PRW), .DEPTH(NCP)) u_prod (
    .clk(clk), .we(v2), .addr(pptr),
    .wdata({p2_re, p2_im}), .rdata(old_prod));

  logic signed [DW-1:0]  o_i, o_q;
  logic signed [PRW-1:0] mul_re, mul_im, q_re, q_im;
  assign o_i = $signed(old_smp[2*DW-1:DW]);
  assign o_q = $signed(old_smp[DW-1:0]);
  // earlier sample times the conjugate of the later one
  assign mul_re = xp(o_i) * xp(n_i) + xp(o_q) * xp(n_q);
  assign mul_im = xp(o_q) * xp(n_i) - xp(o_i) * xp(n_q);
  assign q_re = $signed(old_prod[2*PRW-1:PRW]);
  assign q_im = $signed(old_prod[PRW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; pptr <= '0; pos <= '0; seen <= '0; cwrap <= 1'b0;
      v1 <= 1'b0; pair1 <= 1'b0; full1 <= 1'b0; pos1 <= '0; n_i <= '0; n_q <= '0;
      v2 <= 1'b0; full2 <= 1'b0; pos2 <= '0; p2_re <= '0; p2_im <= '0;
      v3 <= 1'b0; full3 <= 1'b0; ok3 <= 1'b0; pos3 <= '0; p3_re <= '0; p3_im <= '0;
      s_valid <= 1'b0; s_full <= 1'b0; s_pos <= '0; s_re <= '0; s_im <= '0;
    end else begin
      // stage 0: sample bookkeeping, delay-line access
      v1 <= in_valid;
      if (in_valid) begin
        wptr  <= (wptr == FA'(NFFT-1)) ? '0 : wptr + FA'(1);
        pos   <= (pos == IW'(NSYM-1)) ? '0 : pos + IW'(1);
        seen  <= (seen == (IW+1)'(NSYM)) ? seen : seen + (IW+1)'(1);
        pair1 <= (seen >= (IW+1)'(NFFT));
        full1 <= (seen >= (IW+1)'(NSYM-1));
        pos1  <= pos;
        n_i   <= in_i;
        n_q   <= in_q;
      end
      // stage 1: lag product
      v2 <= v1;
      if (v1) begin
        p2_re <= pair1 ? mul_re : '0;
        p2_im <= pair1 ? mul_im : '0;
        full2 <= full1;
        pos2  <= pos1;
      end
      // stage 2: product window delay
      v3 <= v2;
      if (v2) begin
        pptr  <= (pptr == CA'(NCP-1)) ? '0 : pptr + CA'(1);
        if (pptr == CA'(NCP-1)) cwrap <= 1'b1;
        ok3   <= cwrap;
        p3_re <= p2_re;
        p3_im <= p2_im;
        full3 <= full2;
        pos3  <= pos2;
      end
      // stage 3: running window sum
      s_valid <= v3;
      if (v3) begin
        s_re  <= s_re + xs(p3_re) - (ok3 ? xs(q_re) : '0);
        s_im  <= s_im + xs(p3_im) - (ok3 ? xs(q_im) : '0);
        s_pos <= pos3;
        s_full <= full3;
      end
    end
  end
endmodule

// File: rtl/cpt_peak.sv
module cpt_peak #(
  parameter int NSYM = 2560,
  parameter int SW   = 42,
  localparam int IW  = $clog2(NSYM),
  localparam int MW  = 2*SW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  input  logic                 s_full,
  input  logic [IW-1:0]        s_pos,
  input  logic signed [SW-1:0] s_re,
  input  logic signed [SW-1:0] s_im,
  output logic                 pk_done,
  output logic [IW-1:0]        pk_start,
  output logic signed [SW-1:0] pk_re,
  output logic signed [SW-1:0] pk_im
);
  logic signed [MW-1:0] re_x, im_x, rr, ii;
  logic [MW-1:0]        mag, best;
  logic [IW-1:0]        nidx, bidx;
  logic signed [SW-1:0] b_re, b_im;
  logic                 armed, take;

  assign re_x = {{SW{s_re[SW-1]}}, s_re};
  assign im_x = {{SW{s_im[SW-1]}}, s_im};
  assign rr   = re_x * re_x;
  assign ii   = im_x * im_x;
  assign mag  = $unsigned(rr) + $unsigned(ii);
  // strict compare keeps the earliest index on ties
  assign take = (s_pos == '0) || (mag > best);
  assign nidx = (s_pos == IW'(NSYM-1)) ? '0 : s_pos + IW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0; best <= '0; bidx <= '0; b_re <= '0; b_im <= '0;
      pk_done <= 1'b0; pk_start <= '0; pk_re <= '0; pk_im <= '0;
    end else begin
      pk_done <= 1'b0;
      if (s_valid && s_full) begin
        if (s_pos == '0) armed <= 1'b1;
        if (take) begin
          best <= mag; bidx <= nidx; b_re <= s_re; b_im <= s_im;
        end
        if (s_pos == IW'(NSYM-1) && armed) begin
          pk_done  <= 1'b1;
          pk_start <= take ? nidx : bidx;
          pk_re    <= take ? s_re : b_re;
          pk_im    <= take ? s_im : b_im;
        end
      end
    end
  end
endmodule

// File: rtl/cpt_angle.sv
module cpt_angle
  import cpt_pkg::*;
#(
  parameter int SW   = 42,
  parameter int PW   = 16,
  parameter int ITER = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [SW-1:0] x_in,
  input  logic signed [SW-1:0] y_in,
  output logic                 done,
  output logic [PW-1:0]        phase
);
  localparam int CW = SW + 2;

  logic                 busy;
  logic [3:0]           it;
  logic signed [CW-1:0] cx, cy, xe, ye;
  logic [PW-1:0]        cz, step, z_nx;

  assign xe   = {{2{x_in[SW-1]}}, x_in};
  assign ye   = {{2{y_in[SW-1]}}, y_in};
  assign step = PW'(atan_turn16(it) >> (16 - PW));
  assign z_nx = cy[CW-1] ? cz - step : cz + step;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; it <= '0; cx <= '0; cy <= '0; cz <= '0;
      done <= 1'b0; phase <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        it   <= '0;
        if (xe[CW-1]) begin
          cx <= -xe; cy <= -ye; cz <= PW'(1) << (PW-1);
        end else begin
          cx <= xe; cy <= ye; cz <= '0;
        end
      end else if (busy) begin
        if (cy[CW-1]) begin
          cx <= cx - (cy >>> it);
          cy <= cy + (cx >>> it);
        end else begin
          cx <= cx + (cy >>> it);
          cy <= cy - (cx >>> it);
        end
        cz <= z_nx;
        it <= it + 4'd1;
        if (it == 4'(ITER-1)) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          phase <= z_nx;
        end
      end
    end
  end
endmodule

// File: rtl/cp_sym_timing.sv
module cp_sym_timing #(
  parameter int DW          = 16,
  parameter int NFFT        = 2048,
  parameter int NCP         = 512,
  parameter int PHASE_W     = 16,
  parameter int CORDIC_ITER = 12,
  localparam int NSYM  = NFFT + NCP,
  localparam int IDX_W = $clog2(NSYM),
  localparam int SUM_W = 2*DW + 1 + $clog2(NCP)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [DW-1:0]       in_i,
  input  logic [DW-1:0]       in_q,
  output logic                sym_strobe,
  output logic [IDX_W-1:0]    sym_start,
  output logic [PHASE_W-1:0]  freq_phase,
  output logic [IDX_W:0]      drift,
  output logic                drift_valid
);
  logic                    s_valid, s_full;
  logic [IDX_W-1:0]        s_pos;
  logic signed [SUM_W-1:0] s_re, s_im;
  logic                    pk_done, an_done;
  logic [IDX_W-1:0]        pk_start, pend, prev;
  logic signed [SUM_W-1:0] pk_re, pk_im;
  logic [PHASE_W-1:0]      an_phase;
  logic                    have_prev;
  logic [IDX_W:0]          drift_nx;

  cpt_corr #(.DW(DW), .NFFT(NFFT), .NCP(NCP)) u_corr (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_i($signed(in_i)), .in_q($signed(in_q)),
    .s_valid(s_valid), .s_full(s_full), .s_pos(s_pos),
    .s_re(s_re), .s_im(s_im));

  cpt_peak #(.NSYM(NSYM), .SW(SUM_W)) u_peak (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_full(s_full), .s_pos(s_pos),
    .s_re(s_re), .s_im(s_im), .pk_done(pk_done), .pk_start(pk_start),
    .pk_re(pk_re), .pk_im(pk_im));

  cpt_angle #(.SW(SUM_W), .PW(PHASE_W), .ITER(CORDIC_ITER)) u_angle (
    .clk(clk), .rst(rst), .start(pk_done), .x_in(pk_re), .y_in(pk_im),
    .done(an_done), .phase(an_phase));

  always_comb begin
    int dd;
    dd = int'(pend) - int'(prev);
    if (dd > NSYM/2)          dd = dd - NSYM;
    else if (dd <= -(NSYM/2)) dd = dd + NSYM;
    if (!have_prev) dd = 0;
    drift_nx = (IDX_W+1)'(dd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0; prev <= '0; have_prev <= 1'b0;
      sym_strobe <= 1'b0; sym_start <= '0; freq_phase <= '0;
      drift <= '0; drift_valid <= 1'b0;
    end else begin
      sym_strobe <= 1'b0;
      if (pk_done) pend <= pk_start;
      if (an_done) begin
        sym_strobe  <= 1'b1;
        sym_start   <= pend;
        freq_phase  <= an_phase;
        drift       <= drift_nx;
        drift_valid <= have_prev;
        prev        <= pend;
        have_prev   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cp_sym_timing_chk.sv
module cp_sym_timing_chk #(
  parameter int NSYM  = 2560,
  parameter int IDX_W = 12,
  parameter int PW    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_strobe,
  input logic [IDX_W-1:0] sym_start,
  input logic [PW-1:0]    freq_phase,
  input logic [IDX_W:0]   drift,
  input logic             drift_valid
);
  logic           seen;
  logic [IDX_W:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0; gap <= '0;
    end else if (sym_strobe) begin
      seen <= 1'b1; gap <= '0;
    end else if (gap != (IDX_W+1)'(NSYM)) begin
      gap <= gap + (IDX_W+1)'(1);
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sym_strobe |=> !sym_strobe);
  a_r2_period_spacing: assert property (@(posedge clk) disable iff (rst)
    (sym_strobe && seen) |-> (gap >= (IDX_W+1)'(NSYM-1)));
  a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
    !sym_strobe |-> ($stable(sym_start) && $stable(freq_phase) && $stable(drift) && $stable(drift_valid)));
  a_r4_start_in_period: assert property (@(posedge clk) disable iff (rst)
    sym_start < IDX_W'(NSYM));
  a_r7_drift_wrapped: assert property (@(posedge clk) disable iff (rst)
    sym_strobe |-> ($signed(drift) > -(NSYM/2) && $signed(drift) <= NSYM/2));
  a_r8_first_no_drift: assert property (@(posedge clk) disable iff (rst)
    (sym_strobe && !seen) |-> (!drift_valid && drift == '0));
  a_r8_later_drift: assert property (@(posedge clk) disable iff (rst)
    (sym_strobe && seen) |-> drift_valid);
endmodule

bind cp_sym_timing cp_sym_timing_chk #(.NSYM(NSYM), .IDX_W(IDX_W), .PW(PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .sym_strobe(sym_strobe), .sym_start(sym_start),
  .freq_phase(freq_phase), .drift(drift), .drift_valid(drift_valid));

// File: tb/sim_cp_sym_timing.sv
module sim_cp_sym_timing;
  localparam int NFFT = 32, NCP = 16, NSYM = 48, PW = 16, IW = 6;
  localparam int MAXS = 1200;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [15:0] in_i = '0, in_q = '0;
  wire sym_strobe, drift_valid;
  wire [IW-1:0] sym_start;
  wire [PW-1:0] freq_phase;
  wire [IW:0]   drift;

  always #10 clk = ~clk;

  cp_sym_timing #(.DW(16), .NFFT(NFFT), .NCP(NCP), .PHASE_W(PW), .CORDIC_ITER(12)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .sym_strobe(sym_strobe), .sym_start(sym_start), .freq_phase(freq_phase),
    .drift(drift), .drift_valid(drift_valid));

  int total = 0, bad = 0;
  int sx_i[MAXS], sx_q[MAXS];
  int ns = 0;
  int cap_n = 0;
  int cap_start[64], cap_phase[64], cap_drift[64];
  bit cap_dv[64];

  always @(negedge clk) begin
    if (!rst && sym_strobe && cap_n < 64) begin
      cap_start[cap_n] = int'(sym_start);
      cap_phase[cap_n] = int'(freq_phase);
      cap_drift[cap_n] = int'($signed(drift));
      cap_dv[cap_n]    = drift_valid;
      cap_n++;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_phase(string req, int act, int exp);
    int d;
    total++;
    d = ((act - exp) % 65536 + 65536) % 65536;
    if (d > 32768) d = d - 65536;
    if (d > 16 || d < -16) begin
      bad++;
      $display("FAIL %s phase: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    cap_n = 0;
    rst = 1'b0;
  endtask

  function automatic int rnd();
    return int'($urandom_range(6000)) - 3000;
  endfunction

  // off leading filler samples, nsyms symbols with prefix, optional slip sample
  task automatic build(int off, int nsyms, int slip_after, real omega);
    int bi[NFFT], bq[NFFT];
    int ti, tq;
    ns = 0;
    for (int k = 0; k < off; k++) begin sx_i[ns] = rnd(); sx_q[ns] = rnd(); ns++; end
    for (int s = 0; s < nsyms; s++) begin
      for (int k = 0; k < NFFT; k++) begin bi[k] = rnd(); bq[k] = rnd(); end
      for (int k = NFFT-NCP; k < NFFT; k++) begin sx_i[ns] = bi[k]; sx_q[ns] = bq[k]; ns++; end
      for (int k = 0; k < NFFT; k++) begin sx_i[ns] = bi[k]; sx_q[ns] = bq[k]; ns++; end
      if (s == slip_after) begin sx_i[ns] = rnd(); sx_q[ns] = rnd(); ns++; end
    end
    if (omega != 0.0) begin
      for (int m = 0; m < ns; m++) begin
        ti = $rtoi(sx_i[m] * $cos(omega*m) - sx_q[m] * $sin(omega*m));
        tq = $rtoi(sx_i[m] * $sin(omega*m) + sx_q[m] * $cos(omega*m));
        sx_i[m] = ti; sx_q[m] = tq;
      end
    end
  endtask

  task automatic feed(bit gaps);
    for (int m = 0; m < ns; m++) begin
      @(negedge clk);
      while (gaps && $urandom_range(2) == 0) begin
        in_valid = 1'b0; in_i = 16'h5a5a; in_q = 16'ha5a5;
        @(negedge clk);
      end
      in_valid = 1'b1; in_i = 16'(sx_i[m]); in_q = 16'(sx_q[m]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  // reference correlation following R3/R4/R5
  task automatic check_stream(string tag);
    int periods, m_best, es, ep, prev_s, d;
    longint sr, si, br, bi, mag, best, pr, pi;
    periods = ns / NSYM;
    chk("R2", {tag, " report count"}, cap_n, periods - 1);
    prev_s = 0;
    for (int r = 0; r < cap_n && r < periods - 1; r++) begin
      best = -1; m_best = 0; br = 0; bi = 0;
      for (int m = (r+1)*NSYM; m < (r+2)*NSYM; m++) begin
        sr = 0; si = 0;
        for (int n = m-NFFT-NCP+1; n <= m-NFFT; n++) begin
          if (n >= 0) begin
            pr = longint'(sx_i[n])*sx_i[n+NFFT] + longint'(sx_q[n])*sx_q[n+NFFT];
            pi = longint'(sx_q[n])*sx_i[n+NFFT] - longint'(sx_i[n])*sx_q[n+NFFT];
            sr += pr; si += pi;
          end
        end
        mag = sr*sr + si*si;
        if (mag > best) begin best = mag; m_best = m; br = sr; bi = si; end
      end
      es = (m_best + 1) % NSYM;
      ep = $rtoi($atan2(real'(bi), real'(br)) * 65536.0 / TWO_PI);
      chk("R4", {tag, " start"}, cap_start[r], es);
      chk_phase({"R6 ", tag}, cap_phase[r], ep);
      if (r == 0) begin
        chk("R8", {tag, " first drift_valid"}, cap_dv[r], 0);
        chk("R8", {tag, " first drift"}, cap_drift[r], 0);
      end else begin
        d = es - prev_s;
        if (d > NSYM/2) d -= NSYM; else if (d <= -(NSYM/2)) d += NSYM;
        chk("R8", {tag, " drift_valid"}, cap_dv[r], 1);
        chk("R7", {tag, " drift"}, cap_drift[r], d);
      end
      prev_s = es;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "strobe in reset", sym_strobe, 0);
    chk("R1", "start in reset", sym_start, 0);
    chk("R1", "phase in reset", freq_phase, 0);
    chk("R1", "drift in reset", drift, 0);
    chk("R1", "drift_valid in reset", drift_valid, 0);
  endtask

  task automatic t_aligned();
    do_reset(); build(5, 10, -1, 0.0); feed(1'b0); check_stream("aligned");
  endtask

  task automatic t_freq();
    do_reset(); build(30, 8, -1, 0.03); feed(1'b0); check_stream("freq_neg");
    do_reset(); build(17, 8, -1, -0.09); feed(1'b0); check_stream("freq_wide");
  endtask

  task automatic t_gaps();
    do_reset(); build(11, 8, -1, 0.01); feed(1'b1); check_stream("R10 gaps");
  endtask

  task automatic t_slip();
    do_reset(); build(NSYM-1, 9, 3, 0.0); feed(1'b0); check_stream("R7 slip_wrap");
  endtask

  task automatic t_fullscale();
    do_reset();
    ns = 4*NSYM;
    for (int m = 0; m < ns; m++) begin sx_i[m] = -32768; sx_q[m] = -32768; end
    feed(1'b0);
    chk("R9", "fullscale report count", cap_n, 3);
    for (int r = 0; r < cap_n && r < 3; r++) begin
      chk("R5", "fullscale tie start", cap_start[r], 1);
      chk_phase("R9 fullscale", cap_phase[r], 0);
    end
    chk("R7", "fullscale steady drift", cap_drift[1], 0);
  endtask

  task automatic t_zero_tie();
    do_reset();
    ns = 3*NSYM;
    for (int m = 0; m < ns; m++) begin sx_i[m] = 0; sx_q[m] = 0; end
    feed(1'b1);
    chk("R5", "zero input report count", cap_n, 2);
    chk("R5", "zero input tie start", cap_start[0], 1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=completed");
    finish_run();
  end

  initial begin
    t_reset();
    t_aligned();
    t_freq();
    t_gaps();
    t_slip();
    t_fullscale();
    t_zero_tie();
    finish_run();
  end
endmodule